// File: doc/BRIEF.md
# SIMD Byte-Load Lane Formatter

This execution-stage block carries out a single-byte load into one of sixteen 32-bit SIMD extension registers. On acceptance it splits the instruction fields into a destination register index, a signed 8-bit displacement, a 3-bit placement pattern and a base general-register index. It adds the displacement to the base register value and sends one byte read to memory. When the byte returns, the block writes the destination register with that byte arranged in one of eight ways.

Four patterns put the byte into a single lane and keep the other three lanes of the old register value. That old value is read through the register-file read port and latched when the instruction is accepted. The other four patterns build the whole word from the byte alone: two halfword lanes with zero fill in the upper or lower byte, two halfword lanes with sign fill, or all four lanes holding the byte. If the extension enable input is low when the instruction is accepted, the block discards the instruction. In that case it sends no memory request and makes no register write.

The core supplies the instruction's field bits as `instr_word[25:6]`, keeping their instruction bit numbering. The general register file and the extension register file answer their read ports in the same cycle.

Top module: `simd_byte_lane_loader`

## Requirements
- R1: Fields are taken from the instruction as follows: destination extension register = bits [9:6], displacement = bits [17:10], pattern = bits [20:18], base general register = bits [25:21]. `gpr_raddr` and `xr_raddr` show the base and destination indices of the word presented, and `xr_waddr` equals the destination index at writeback.
- R2: `mem_req_addr` equals the base register value plus the displacement sign-extended to 32 bits, modulo 2^32.
- R3: An instruction accepted while `ext_enable` is 0 raises `busy` for exactly one cycle. It produces no memory request and no register write.
- R4: Patterns 0, 1, 2 and 3 replace bits [7:0], [15:8], [23:16] and [31:24] of the destination with the loaded byte. The other three bytes keep the value the register held at acceptance.
- R5: Pattern 4 writes {8'h00, b, 8'h00, b} and pattern 5 writes {b, 8'h00, b, 8'h00}, where b is the loaded byte.
- R6: Pattern 6 writes {s, b, s, b}, where s is eight copies of bit 7 of b.
- R7: Pattern 7 writes {b, b, b, b}.
- R8: Each enabled instruction issues exactly one request. `mem_req_valid` stays high with a stable address until `mem_req_ready` is seen, and drops in the cycle after the handshake.
- R9: `xr_we` is high for exactly one cycle, in the cycle after `mem_rsp_valid` is sampled high.
- R10: `busy` rises in the cycle after an instruction is accepted and falls after writeback. An instruction is accepted only when `instr_valid` is high and `busy` is low.
- R11: While `rst_n` is low the block returns to idle with `busy`, `mem_req_valid` and `xr_we` low. It makes no register write during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction offered |
| instr_word | input | 20 | Instruction bits [25:6] |
| ext_enable | input | 1 | Extension enable bit from the control register |
| busy | output | 1 | Instruction in flight; no new instruction taken |
| gpr_raddr | output | 5 | Base general-register read index |
| gpr_rdata | input | 32 | Base general-register value |
| xr_raddr | output | 4 | Destination extension-register read index |
| xr_rdata | input | 32 | Old destination value |
| mem_req_valid | output | 1 | Byte read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_byte | input | 8 | Returned byte |
| xr_we | output | 1 | Extension register write strobe |
| xr_waddr | output | 4 | Write index |
| xr_wdata | output | 32 | Formatted write data |

## Verification
The assertions take for granted that memory sends a response only after the request handshake, and only one response per request. They also assume that `rst_n` is driven low from the first clock edge. The bench keeps to this by raising `mem_rsp_valid` for a single cycle, only after the handshake cycle has passed. It also offers spurious instructions while the block is busy and varies the request-ready delay. It sweeps every pattern and destination against boundary bytes and displacements, and it checks one reset taken in the middle of an instruction.

// File: rtl/slb_pkg.sv
// Package: shared widths, field positions, field struct and controller state
// for the byte-load lane formatter. Assumes a 32-bit word split into 8-bit lanes.
package slb_pkg;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned LANE_W     = 8;
    localparam int unsigned LANES      = WORD_W / LANE_W;
    localparam int unsigned LANE_SEL_W = $clog2(LANES);
    localparam int unsigned XR_COUNT   = 16;
    localparam int unsigned XR_IDX_W   = $clog2(XR_COUNT);
    localparam int unsigned GPR_IDX_W  = 5;
    localparam int unsigned DISP_W     = 8;
    localparam int unsigned PAT_W      = 3;

    // Field positions within the instruction word (decoded by the core's neighbours too)
    localparam int unsigned DEST_LSB = 6;
    localparam int unsigned DISP_LSB = DEST_LSB + XR_IDX_W;
    localparam int unsigned PAT_LSB  = DISP_LSB + DISP_W;
    localparam int unsigned BASE_LSB = PAT_LSB + PAT_W;
    localparam int unsigned FIELD_LO = DEST_LSB;
    localparam int unsigned FIELD_HI = BASE_LSB + GPR_IDX_W - 1;

    typedef struct packed {
        logic [GPR_IDX_W-1:0] base;
        logic [PAT_W-1:0]     pat;
        logic [DISP_W-1:0]    disp;
        logic [XR_IDX_W-1:0]  dest;
    } slb_fields_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DROP,
        ST_REQ,
        ST_WAIT,
        ST_WB
    } slb_state_t;
endpackage

// File: rtl/slb_decode.sv
// Module: slb_decode
// Splits the instruction field bits into destination, displacement, pattern and
// base, and forms the byte address from the base value plus the sign-extended
// displacement. Purely combinational; assumes the base value is already read.
module slb_decode
    import slb_pkg::*;
(
    input  logic [FIELD_HI:FIELD_LO] instr,
    input  logic [WORD_W-1:0]        base_val,
    output slb_fields_t              fields,
    output logic [WORD_W-1:0]        addr
);
    // Field extraction at fixed instruction positions
    always_comb begin
        fields.dest = instr[DEST_LSB +: XR_IDX_W];
        fields.disp = instr[DISP_LSB +: DISP_W];
        fields.pat  = instr[PAT_LSB  +: PAT_W];
        fields.base = instr[BASE_LSB +: GPR_IDX_W];
    end

    // Effective address: wraps modulo 2^WORD_W
    always_comb begin
        addr = base_val + {{(WORD_W-DISP_W){fields.disp[DISP_W-1]}}, fields.disp};
    end
endmodule

// File: rtl/slb_ctrl.sv
// Module: slb_ctrl
// Sequences one instruction: accept, optional discard, request, wait for the
// byte, single-cycle writeback. Assumes memory answers once per accepted request
// and never before the request handshake.
module slb_ctrl
    import slb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic instr_valid,
    input  logic ext_enable,
    input  logic mem_req_ready,
    input  logic mem_rsp_valid,
    output logic accept,
    output logic issue_capture,
    output logic rsp_capture,
    output logic busy,
    output logic mem_req_valid,
    output logic xr_we
);
    slb_state_t state_q, state_d;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (instr_valid) state_d = ext_enable ? ST_REQ : ST_DROP;
            ST_DROP: state_d = ST_IDLE;
            ST_REQ:  if (mem_req_ready) state_d = ST_WAIT;
            ST_WAIT: if (mem_rsp_valid) state_d = ST_WB;
            ST_WB:   state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Decoded strobes and status
    always_comb begin
        accept        = instr_valid && (state_q == ST_IDLE);
        issue_capture = accept && ext_enable;
        rsp_capture   = (state_q == ST_WAIT) && mem_rsp_valid;
        busy          = (state_q != ST_IDLE);
        mem_req_valid = (state_q == ST_REQ);
        xr_we         = (state_q == ST_WB);
    end

    assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);
    assert_drop_is_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !ext_enable) |=> (busy && !mem_req_valid && !xr_we));
    assert_write_follows_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        xr_we |-> $past(mem_rsp_valid));
    assert_write_single_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        xr_we |=> !xr_we);
    assert_reset_no_write_R11: assert property (@(posedge clk)
        !rst_n |=> (!xr_we && !busy));
endmodule

// File: rtl/slb_format.sv
// Module: slb_format
// Builds the write word from the loaded byte, the placement pattern and the old
// register value. Pattern bit 2 clear: insert into the lane named by bits [1:0].
// Pattern bit 2 set: zero-fill halves (4, 5), sign-fill halves (6), replicate (7).
module slb_format
    import slb_pkg::*;
(
    input  logic [PAT_W-1:0]  pat,
    input  logic [LANE_W-1:0] byte_in,
    input  logic [WORD_W-1:0] old_word,
    output logic [WORD_W-1:0] word_out
);
    logic [LANE_W-1:0] sign_fill;

    // Sign extension byte for pattern 6
    always_comb sign_fill = {LANE_W{byte_in[LANE_W-1]}};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam bit ODD = (g % 2) == 1;
        // Per-lane byte selection
        always_comb begin
            if (!pat[2]) begin
                word_out[g*LANE_W +: LANE_W] = (pat[LANE_SEL_W-1:0] == LANE_SEL_W'(g))
                                             ? byte_in : old_word[g*LANE_W +: LANE_W];
            end else begin
                unique case (pat[1:0])
                    2'd0:    word_out[g*LANE_W +: LANE_W] = ODD ? '0 : byte_in;
                    2'd1:    word_out[g*LANE_W +: LANE_W] = ODD ? byte_in : '0;
                    2'd2:    word_out[g*LANE_W +: LANE_W] = ODD ? sign_fill : byte_in;
                    default: word_out[g*LANE_W +: LANE_W] = byte_in;
                endcase
            end
        end
    end
endmodule

// File: rtl/simd_byte_lane_loader.sv
// Module: simd_byte_lane_loader
// Top of the byte-load lane formatter. Latches address, pattern, destination and
// old register value at acceptance, runs the memory handshake, and writes the
// formatted word one cycle after the byte returns. Assumes same-cycle read ports
// on both register files.
module simd_byte_lane_loader
    import slb_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     instr_valid,
    input  logic [FIELD_HI:FIELD_LO] instr_word,
    input  logic                     ext_enable,
    output logic                     busy,
    output logic [GPR_IDX_W-1:0]     gpr_raddr,
    input  logic [WORD_W-1:0]        gpr_rdata,
    output logic [XR_IDX_W-1:0]      xr_raddr,
    input  logic [WORD_W-1:0]        xr_rdata,
    output logic                     mem_req_valid,
    input  logic                     mem_req_ready,
    output logic [WORD_W-1:0]        mem_req_addr,
    input  logic                     mem_rsp_valid,
    input  logic [LANE_W-1:0]        mem_rsp_byte,
    output logic                     xr_we,
    output logic [XR_IDX_W-1:0]      xr_waddr,
    output logic [WORD_W-1:0]        xr_wdata
);
    slb_fields_t          fields;
    logic [WORD_W-1:0]    eff_addr;
    logic                 accept, issue_capture, rsp_capture;
    logic [WORD_W-1:0]    addr_q, old_q;
    logic [PAT_W-1:0]     pat_q;
    logic [XR_IDX_W-1:0]  dest_q;
    logic [LANE_W-1:0]    byte_q;

    slb_decode u_decode (
        .instr    (instr_word),
        .base_val (gpr_rdata),
        .fields   (fields),
        .addr     (eff_addr)
    );

    slb_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .instr_valid   (instr_valid),
        .ext_enable    (ext_enable),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .accept        (accept),
        .issue_capture (issue_capture),
        .rsp_capture   (rsp_capture),
        .busy          (busy),
        .mem_req_valid (mem_req_valid),
        .xr_we         (xr_we)
    );

    slb_format u_format (
        .pat      (pat_q),
        .byte_in  (byte_q),
        .old_word (old_q),
        .word_out (xr_wdata)
    );

    // Register-file read indices come straight from the offered instruction
    always_comb begin
        gpr_raddr = fields.base;
        xr_raddr  = fields.dest;
    end

    // Issue-time capture of address, pattern, destination and old value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            old_q  <= '0;
            pat_q  <= '0;
            dest_q <= '0;
        end else if (issue_capture) begin
            addr_q <= eff_addr;
            old_q  <= xr_rdata;
            pat_q  <= fields.pat;
            dest_q <= fields.dest;
        end
    end

    // Response capture of the loaded byte
    always_ff @(posedge clk) begin
        if (!rst_n)           byte_q <= '0;
        else if (rsp_capture) byte_q <= mem_rsp_byte;
    end

    // Outgoing request and write address
    always_comb begin
        mem_req_addr = addr_q;
        xr_waddr     = dest_q;
    end

    assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
    assert_req_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);
    assert_no_accept_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && instr_valid) |=> $stable(mem_req_addr) || !mem_req_valid);
endmodule

// File: tb/simd_byte_lane_loader_bench.sv
module simd_byte_lane_loader_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [25:6] instr_word = '0;
    logic        ext_enable = 1'b0;
    logic        busy;
    logic [4:0]  gpr_raddr;
    logic [31:0] gpr_rdata;
    logic [3:0]  xr_raddr;
    logic [31:0] xr_rdata;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [7:0]  mem_rsp_byte = '0;
    logic        xr_we;
    logic [3:0]  xr_waddr;
    logic [31:0] xr_wdata;

    int          checks = 0;
    int          errors = 0;
    int          wr_count = 0;
    int          exp_wr = 0;
    int          cycles = 0;
    bit          done = 1'b0;
    logic [31:0] xrf [16];

    always #2 clk = ~clk;

    simd_byte_lane_loader u_simd_byte_lane_loader (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .ext_enable(ext_enable), .busy(busy), .gpr_raddr(gpr_raddr), .gpr_rdata(gpr_rdata),
        .xr_raddr(xr_raddr), .xr_rdata(xr_rdata), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_byte(mem_rsp_byte), .xr_we(xr_we),
        .xr_waddr(xr_waddr), .xr_wdata(xr_wdata)
    );

    function automatic logic [31:0] gpr_val(input logic [4:0] i);
        if (i == 5'd31) return 32'hFFFF_FFF8;
        if (i == 5'd0)  return 32'h0;
        return 32'(i) * 32'h0101_0417 + 32'h40;
    endfunction

    assign gpr_rdata = gpr_val(gpr_raddr);
    assign xr_rdata  = xrf[xr_raddr];

    // Count register writes seen at clock edges
    always @(posedge clk) if (rst_n && xr_we) wr_count++;

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, got %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_word(input logic [2:0] p, input logic [7:0] b,
                                                input logic [31:0] old);
        logic [31:0] bw = {24'h0, b};
        case (p)
            3'd4: return bw * 32'h0001_0001;
            3'd5: return bw * 32'h0100_0100;
            3'd6: return bw * 32'h0001_0001 | (b[7] ? 32'hFF00_FF00 : 32'h0);
            3'd7: return bw * 32'h0101_0101;
            default: return (old & ~(32'hFF << (8 * p))) | (bw << (8 * p));
        endcase
    endfunction

    function automatic string pat_req(input logic [2:0] p);
        if (p < 3'd4) return "R4";
        if (p < 3'd6) return "R5";
        if (p == 3'd6) return "R6";
        return "R7";
    endfunction

    task automatic run_instr(input logic [3:0] dest, input logic [7:0] disp, input logic [2:0] pat,
                             input logic [4:0] base, input logic [7:0] b, input int delay, input bit en);
        logic [31:0] exp_addr, old, exp_w;
        exp_addr = gpr_val(base) + {{24{disp[7]}}, disp};
        @(negedge clk);
        instr_valid = 1'b1;
        instr_word  = {base, pat, disp, dest};
        ext_enable  = en;
        #1;
        check(gpr_raddr == base && xr_raddr == dest, "R1 read idx",
              {23'h0, gpr_raddr, xr_raddr}, {23'h0, base, dest});
        old = xrf[dest];
        @(negedge clk);
        instr_valid = 1'b0;
        check(busy == 1'b1, "R10 busy", {31'h0, busy}, 32'h1);
        if (!en) begin
            check(!mem_req_valid && !xr_we, "R3 no req", {30'h0, mem_req_valid, xr_we}, 32'h0);
            @(negedge clk);
            check(busy == 1'b0, "R3 busy one cycle", {31'h0, busy}, 32'h0);
            check(wr_count == exp_wr && xrf[dest] == old, "R3 no write", wr_count, exp_wr);
            return;
        end
        check(mem_req_valid == 1'b1, "R8 req", {31'h0, mem_req_valid}, 32'h1);
        check(mem_req_addr == exp_addr, "R2 addr", mem_req_addr, exp_addr);
        for (int d = 0; d < delay; d++) begin
            instr_valid = 1'b1;
            instr_word  = ~{base, pat, disp, dest};
            @(negedge clk);
            check(mem_req_valid && mem_req_addr == exp_addr, "R8 hold", mem_req_addr, exp_addr);
        end
        instr_valid   = 1'b0;
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        check(!mem_req_valid && !xr_we, "R8 drop", {30'h0, mem_req_valid, xr_we}, 32'h0);
        mem_rsp_valid = 1'b1;
        mem_rsp_byte  = b;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_byte  = ~b;
        exp_w = expect_word(pat, b, old);
        check(xr_we == 1'b1, "R9 strobe", {31'h0, xr_we}, 32'h1);
        check(xr_waddr == dest, "R1 waddr", {28'h0, xr_waddr}, {28'h0, dest});
        check(xr_wdata == exp_w, pat_req(pat), xr_wdata, exp_w);
        xrf[dest] = exp_w;
        exp_wr++;
        @(negedge clk);
        check(!xr_we, "R9 one cycle", {31'h0, xr_we}, 32'h0);
        check(!busy, "R10 idle", {31'h0, busy}, 32'h0);
        check(wr_count == exp_wr, "R9 R10 write count", wr_count, exp_wr);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) xrf[i] = (32'(i) * 32'h1111_1111) ^ 32'hA5A5_0000;
        repeat (3) @(negedge clk);
        check(!busy && !mem_req_valid && !xr_we, "R11 reset", {29'h0, busy, mem_req_valid, xr_we}, 32'h0);
        rst_n = 1'b1;

        for (int p = 0; p < 8; p++) begin
            for (int dst = 0; dst < 16; dst++) begin
                for (int k = 0; k < 5; k++) begin
                    logic [7:0] bb, dd;
                    case (k)
                        0: begin bb = 8'h00; dd = 8'h80; end
                        1: begin bb = 8'h7F; dd = 8'h7F; end
                        2: begin bb = 8'h80; dd = 8'h00; end
                        3: begin bb = 8'hFF; dd = 8'hFF; end
                        default: begin bb = 8'((p * 16 + dst) * 37); dd = 8'(dst * 13); end
                    endcase
                    run_instr(4'(dst), dd, 3'(p), 5'((dst * 3 + k + p) % 32), bb, (dst + k) % 3, 1'b1);
                end
            end
        end

        // Base 31 wraps across zero with a positive displacement (R2)
        run_instr(4'd5, 8'h10, 3'd7, 5'd31, 8'h3C, 0, 1'b1);

        // Discarded instructions across all patterns (R3)
        for (int p = 0; p < 8; p++) run_instr(4'(p * 2), 8'(p), 3'(p), 5'(p + 1), 8'hAA, 0, 1'b0);

        // Reset in the middle of a request (R11)
        @(negedge clk);
        instr_valid = 1'b1;
        ext_enable  = 1'b1;
        instr_word  = {5'd3, 3'd7, 8'h04, 4'd9};
        @(negedge clk);
        instr_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check(!busy && !mem_req_valid && !xr_we, "R11 mid reset",
              {29'h0, busy, mem_req_valid, xr_we}, 32'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(wr_count == exp_wr && !busy, "R11 no write after reset", wr_count, exp_wr);

        // Block works normally after the reset
        run_instr(4'd9, 8'hFE, 3'd2, 5'd4, 8'h5A, 1, 1'b1);

        finish_run();
    end
endmodule